// File: doc/BRIEF.md
# Luma-Chroma Skew Alignment with Raw Blanking Substitution

This block sits in a video pixel path where a luma stream and a chroma stream share one pixel clock and one valid strobe. It moves luma in time relative to chroma by a whole number of samples. The amount is set by a signed 3-bit code with a range of -3 to +3. A positive skew holds luma back. A negative skew holds chroma back instead. Both paths always go through the same number of register stages, so the overall latency does not depend on the code.

The block also has a raw blanking mode for a downstream processor that wants the unfiltered luma waveform during the vertical blanking lines. When this mode is enabled and the output format flag selects 10-bit BT.656, every chroma output sample on a line inside the programmed blanking window is replaced by the luma sample that leaves the block in the same output slot.

The skew code is applied at line boundaries only. All other controls are sampled together with each input sample.

Top module: `lc_skew_vbi`

## Requirements
- R1: Skew codes 000 and 100 give zero skew. The n-th valid output pair carries luma n and chroma n.
- R2: Codes 001, 010 and 011 delay luma by 1, 2 and 3 valid samples, so output n carries luma n-d and chroma n.
- R3: Codes 111, 110 and 101 delay chroma by 1, 2 and 3 valid samples, so output n carries luma n and chroma n-d.
- R4: Each valid input sample produces exactly one valid output, 4 clock cycles after the edge that captures it, for every skew code.
- R5: Idle cycles (valid low) do not advance the delay lines and do not change the outputs, so alignment counts valid samples only.
- R6: A new skew code takes effect on the first valid sample whose line number differs from that of the previous valid sample (or on the first sample after reset). Code changes in the middle of a line are ignored until then.
- R7: Synchronous active-high reset clears the outputs and the valid flag to zero and fills the delay lines with zero. A skewed stream after reset therefore starts with zero samples on the delayed path.
- R8: When raw mode is on and the 10-bit BT.656 flag is 1, output chroma equals output luma for samples whose line number L satisfies start <= L < stop.
- R9: The window includes the start line and excludes the stop line. If start >= stop the window is empty and no substitution happens.
- R10: When raw mode is off, or the format flag is 0, chroma passes through unchanged on every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample strobe for luma, chroma and controls |
| in_luma | input | DW (10) | Luma sample |
| in_chroma | input | DW (10) | Chroma sample |
| line_num | input | LW (11) | Line number of the current sample |
| skew_code | input | 3 | Signed skew code; 0xx delays luma, 1xx (not 100) delays chroma |
| raw_vbi_en | input | 1 | Enables chroma-to-luma substitution in the blanking window |
| fmt_656_10b | input | 1 | 1 when the output format is 10-bit BT.656 |
| vblk_first | input | LW (11) | First line of the blanking window (inclusive) |
| vblk_last | input | LW (11) | Line that ends the blanking window (exclusive) |
| out_vld | output | 1 | Output sample strobe |
| out_luma | output | DW (10) | Aligned luma |
| out_chroma | output | DW (10) | Aligned, possibly substituted chroma |

## Verification
The hardest case to reach is a code change that arrives in the middle of a line. Its effect is hidden until the next line number shows up on a valid sample, and the samples that follow then repeat or skip history across the boundary. The bench drives a code that changes partway through a line, with valid gaps in between. It compares each output against a model that takes the code from the first sample of each line and the delayed samples from the full valid-only history. The model therefore also covers the zero-filled taps right after reset.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  localparam int MAX_SKEW = 3;
  localparam int TAP_W    = $clog2(MAX_SKEW + 1);

  typedef struct packed {
    logic [TAP_W-1:0] luma_dly;
    logic [TAP_W-1:0] chroma_dly;
  } skew_taps_t;

  // Positive codes hold luma back; negative codes (two's complement) hold chroma back.
  function automatic skew_taps_t decode_skew(input logic [2:0] code);
    skew_taps_t t;
    if (!code[2]) begin
      t.luma_dly   = code[1:0];
      t.chroma_dly = '0;
    end else begin
      t.luma_dly   = '0;
      t.chroma_dly = 2'd0 - code[1:0];
    end
    return t;
  endfunction

endpackage

// File: rtl/lcs_in_stage.sv
module lcs_in_stage #(
  parameter int DW = 10,
  parameter int LW = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [DW-1:0]         in_luma,
  input  logic [DW-1:0]         in_chroma,
  input  logic [LW-1:0]         line_num,
  input  logic [2:0]            skew_code,
  input  logic                  raw_vbi_en,
  input  logic                  fmt_656_10b,
  input  logic [LW-1:0]         vblk_first,
  input  logic [LW-1:0]         vblk_last,
  output logic                  s1_vld,
  output logic [DW-1:0]         s1_luma,
  output logic [DW-1:0]         s1_chroma,
  output logic [LW-1:0]         s1_line,
  output logic                  s1_raw,
  output logic                  s1_fmt,
  output logic [LW-1:0]         s1_first,
  output logic [LW-1:0]         s1_last,
  output lcs_pkg::skew_taps_t   s1_taps
);

  logic          seen_q;
  logic [LW-1:0] prev_line_q;
  logic          s1_new;
  logic [2:0]    s1_code;
  logic [2:0]    act_code;
  logic [2:0]    eff_code;
  logic          line_edge;

  assign line_edge = in_vld && (!seen_q || (line_num != prev_line_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      prev_line_q <= '0;
      s1_vld      <= 1'b0;
      s1_new      <= 1'b0;
      s1_code     <= '0;
      s1_luma     <= '0;
      s1_chroma   <= '0;
      s1_line     <= '0;
      s1_raw      <= 1'b0;
      s1_fmt      <= 1'b0;
      s1_first    <= '0;
      s1_last     <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        seen_q      <= 1'b1;
        prev_line_q <= line_num;
        s1_new      <= line_edge;
        s1_code     <= skew_code;
        s1_luma     <= in_luma;
        s1_chroma   <= in_chroma;
        s1_line     <= line_num;
        s1_raw      <= raw_vbi_en;
        s1_fmt      <= fmt_656_10b;
        s1_first    <= vblk_first;
        s1_last     <= vblk_last;
      end
    end
  end

  // Code is only adopted on the first sample of a line.
  assign eff_code = (s1_vld && s1_new) ? s1_code : act_code;
  assign s1_taps  = lcs_pkg::decode_skew(eff_code);

  always_ff @(posedge clk) begin
    if (rst)                  act_code <= '0;
    else if (s1_vld && s1_new) act_code <= s1_code;
  end

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(s1_vld && s1_new) |=> $stable(act_code));

endmodule

// File: rtl/lcs_delay_line.sv
module lcs_delay_line #(
  parameter int DW   = 10,
  parameter int MAXD = 3,
  localparam int SELW = $clog2(MAXD + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [DW-1:0]   din,
  input  logic [SELW-1:0] sel,
  output logic [DW-1:0]   dout
);

  logic [DW-1:0] hist [1:MAXD];
  logic [DW-1:0] tap  [0:MAXD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= MAXD; k++) hist[k] <= '0;
    end else if (adv) begin
      hist[1] <= din;
      for (int k = 2; k <= MAXD; k++) hist[k] <= hist[k-1];
    end
  end

  always_comb begin
    tap[0] = din;
    for (int k = 1; k <= MAXD; k++) tap[k] = hist[k];
  end

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (adv) dout <= tap[sel];
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(dout));

endmodule

// File: rtl/lcs_vbi_sub.sv
module lcs_vbi_sub #(
  parameter int DW = 10,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic [DW-1:0] luma,
  input  logic [DW-1:0] chroma,
  input  logic [LW-1:0] line,
  input  logic          raw_en,
  input  logic          fmt10,
  input  logic [LW-1:0] win_first,
  input  logic [LW-1:0] win_last,
  output logic          o_vld,
  output logic [DW-1:0] o_luma,
  output logic [DW-1:0] o_chroma
);

  logic in_win;
  logic swap;

  assign in_win = (line >= win_first) && (line < win_last);
  assign swap   = raw_en && fmt10 && in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld    <= 1'b0;
      o_luma   <= '0;
      o_chroma <= '0;
    end else begin
      o_vld <= vld;
      if (vld) begin
        o_luma   <= luma;
        o_chroma <= swap ? luma : chroma;
      end
    end
  end

  // R10
  mode_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && (!fmt10 || !raw_en)) |=> (o_chroma == $past(chroma)));

  // R9
  empty_win_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && (win_first >= win_last)) |=> (o_chroma == $past(chroma)));

  // R8
  swap_luma_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && raw_en && fmt10 && (line >= win_first) && (line < win_last))
      |=> (o_chroma == $past(luma)));

endmodule

// File: rtl/lc_skew_vbi.sv
module lc_skew_vbi #(
  parameter int DW = 10,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] in_luma,
  input  logic [DW-1:0] in_chroma,
  input  logic [LW-1:0] line_num,
  input  logic [2:0]    skew_code,
  input  logic          raw_vbi_en,
  input  logic          fmt_656_10b,
  input  logic [LW-1:0] vblk_first,
  input  logic [LW-1:0] vblk_last,
  output logic          out_vld,
  output logic [DW-1:0] out_luma,
  output logic [DW-1:0] out_chroma
);

  logic                s1_vld, s1_raw, s1_fmt;
  logic [DW-1:0]       s1_luma, s1_chroma;
  logic [LW-1:0]       s1_line, s1_first, s1_last;
  lcs_pkg::skew_taps_t s1_taps;

  logic                s2_vld, s2_raw, s2_fmt;
  logic [DW-1:0]       s2_luma, s2_chroma;
  logic [LW-1:0]       s2_line, s2_first, s2_last;

  logic                s3_vld;
  logic [DW-1:0]       s3_luma, s3_chroma;

  lcs_in_stage #(.DW(DW), .LW(LW)) u_in (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_luma(in_luma), .in_chroma(in_chroma),
    .line_num(line_num), .skew_code(skew_code), .raw_vbi_en(raw_vbi_en),
    .fmt_656_10b(fmt_656_10b), .vblk_first(vblk_first), .vblk_last(vblk_last),
    .s1_vld(s1_vld), .s1_luma(s1_luma), .s1_chroma(s1_chroma), .s1_line(s1_line),
    .s1_raw(s1_raw), .s1_fmt(s1_fmt), .s1_first(s1_first), .s1_last(s1_last),
    .s1_taps(s1_taps)
  );

  lcs_delay_line #(.DW(DW), .MAXD(lcs_pkg::MAX_SKEW)) u_luma_dl (
    .clk(clk), .rst(rst), .adv(s1_vld), .din(s1_luma),
    .sel(s1_taps.luma_dly), .dout(s2_luma)
  );

  lcs_delay_line #(.DW(DW), .MAXD(lcs_pkg::MAX_SKEW)) u_chroma_dl (
    .clk(clk), .rst(rst), .adv(s1_vld), .din(s1_chroma),
    .sel(s1_taps.chroma_dly), .dout(s2_chroma)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld   <= 1'b0;
      s2_raw   <= 1'b0;
      s2_fmt   <= 1'b0;
      s2_line  <= '0;
      s2_first <= '0;
      s2_last  <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_raw   <= s1_raw;
        s2_fmt   <= s1_fmt;
        s2_line  <= s1_line;
        s2_first <= s1_first;
        s2_last  <= s1_last;
      end
    end
  end

  lcs_vbi_sub #(.DW(DW), .LW(LW)) u_sub (
    .clk(clk), .rst(rst), .vld(s2_vld), .luma(s2_luma), .chroma(s2_chroma),
    .line(s2_line), .raw_en(s2_raw), .fmt10(s2_fmt),
    .win_first(s2_first), .win_last(s2_last),
    .o_vld(s3_vld), .o_luma(s3_luma), .o_chroma(s3_chroma)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_luma   <= '0;
      out_chroma <= '0;
    end else begin
      out_vld <= s3_vld;
      if (s3_vld) begin
        out_luma   <= s3_luma;
        out_chroma <= s3_chroma;
      end
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_luma) && $stable(out_chroma)));

endmodule

// File: tb/test_lc_skew_vbi.sv
module test_lc_skew_vbi;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [9:0]  in_luma = '0, in_chroma = '0;
  logic [10:0] line_num = '0, vblk_first = '0, vblk_last = '0;
  logic [2:0]  skew_code = '0;
  logic        raw_vbi_en = 1'b0, fmt_656_10b = 1'b0;
  logic        out_vld;
  logic [9:0]  out_luma, out_chroma;

  always #2 clk = ~clk;

  lc_skew_vbi i_lc_skew_vbi (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_luma(in_luma), .in_chroma(in_chroma),
    .line_num(line_num), .skew_code(skew_code), .raw_vbi_en(raw_vbi_en),
    .fmt_656_10b(fmt_656_10b), .vblk_first(vblk_first), .vblk_last(vblk_last),
    .out_vld(out_vld), .out_luma(out_luma), .out_chroma(out_chroma)
  );

  int checks = 0, fails = 0, cyc = 0, icnt = 0, ocnt = 0, first_out = -1;
  bit done = 0;
  logic [9:0]  sl [64], sc [64], ol [64], oc [64];
  logic [10:0] sln [64], sst [64], ssp [64];
  logic [2:0]  scode [64];
  logic        sen [64], smd [64];

  typedef struct packed {
    logic [2:0] code; logic en; logic md; logic [7:0] st; logic [7:0] sp;
    logic [3:0] req; logic gaps;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd0, 1'b0, 1'b0, 8'd0, 8'd0, 4'd1,  1'b0},
    '{3'd4, 1'b0, 1'b0, 8'd0, 8'd0, 4'd1,  1'b0},
    '{3'd1, 1'b0, 1'b0, 8'd0, 8'd0, 4'd2,  1'b0},
    '{3'd3, 1'b0, 1'b0, 8'd0, 8'd0, 4'd2,  1'b0},
    '{3'd7, 1'b0, 1'b0, 8'd0, 8'd0, 4'd3,  1'b0},
    '{3'd5, 1'b0, 1'b0, 8'd0, 8'd0, 4'd3,  1'b0},
    '{3'd2, 1'b0, 1'b0, 8'd0, 8'd0, 4'd5,  1'b1},
    '{3'd6, 1'b1, 1'b1, 8'd6, 8'd7, 4'd8,  1'b1},
    '{3'd0, 1'b1, 1'b1, 8'd7, 8'd7, 4'd9,  1'b0},
    '{3'd1, 1'b1, 1'b0, 8'd5, 8'd8, 4'd10, 1'b0},
    '{3'd0, 1'b0, 1'b1, 8'd5, 8'd8, 4'd10, 1'b0},
    '{3'd3, 1'b1, 1'b1, 8'd7, 8'd5, 4'd9,  1'b1}
  };

  function automatic string rq(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (ocnt < 64) begin ol[ocnt] = out_luma; oc[ocnt] = out_chroma; end
      if (first_out < 0) first_out = cyc;
      ocnt++;
    end
  end

  task automatic chk(input string r, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    icnt = 0; ocnt = 0; first_out = -1;
  endtask

  task automatic send(input logic [9:0] l, input logic [9:0] c, input logic [10:0] ln,
                      input logic [2:0] code, input logic en, input logic md,
                      input logic [10:0] st, input logic [10:0] sp);
    @(posedge clk); #1;
    in_vld = 1'b1; in_luma = l; in_chroma = c; line_num = ln; skew_code = code;
    raw_vbi_en = en; fmt_656_10b = md; vblk_first = st; vblk_last = sp;
    sl[icnt] = l; sc[icnt] = c; sln[icnt] = ln; scode[icnt] = code;
    sen[icnt] = en; smd[icnt] = md; sst[icnt] = st; ssp[icnt] = sp;
    icnt++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1 in_vld = 1'b0; skew_code = 3'd0;
    end
  endtask

  // Model: code from each line's first sample, taps over valid-only history, zero before start.
  task automatic verify(input string r);
    int dl, dc;
    logic [2:0] act;
    logic [9:0] el, ec;
    idle(8);
    chk(r, "output count", ocnt, icnt);
    act = 3'd0;
    for (int i = 0; i < icnt; i++) begin
      if (i == 0 || sln[i] != sln[i-1]) act = scode[i];
      dl = 0; dc = 0;
      if (act >= 3'd1 && act <= 3'd3) dl = int'(act);
      if (act >= 3'd5) dc = 8 - int'(act);
      el = (i >= dl) ? sl[i-dl] : 10'd0;
      ec = (i >= dc) ? sc[i-dc] : 10'd0;
      if (sen[i] && smd[i] && sln[i] >= sst[i] && sln[i] < ssp[i]) ec = el;
      chk(r, $sformatf("luma[%0d]", i), int'(ol[i]), int'(el));
      chk(r, $sformatf("chroma[%0d]", i), int'(oc[i]), int'(ec));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: reset state at the ports
    @(negedge clk);
    chk("R7", "out_vld after reset", int'(out_vld), 0);
    chk("R7", "out_luma after reset", int'(out_luma), 0);
    chk("R7", "out_chroma after reset", int'(out_chroma), 0);

    // Table walk: R1 R2 R3 R5 R8 R9 R10 scenarios
    for (int v = 0; v < 12; v++) begin
      do_reset();
      for (int ln = 0; ln < 3; ln++) begin
        for (int s = 0; s < 6; s++) begin
          send(10'((v << 5) + ln * 8 + s + 1), 10'(512 + (v << 5) + ln * 8 + s + 1),
               11'(5 + ln), VECS[v].code, VECS[v].en, VECS[v].md,
               11'(VECS[v].st), 11'(VECS[v].sp));
          if (VECS[v].gaps && s[0]) idle(2);
        end
      end
      verify(rq(int'(VECS[v].req)));
    end

    // R7: delayed path starts from zero-filled history after reset
    do_reset();
    for (int s = 0; s < 5; s++) send(10'(40 + s), 10'(80 + s), 11'd3, 3'd3, 1'b0, 1'b0, 11'd0, 11'd0);
    idle(8);
    chk("R7", "first luma after reset with skew 3", int'(ol[0]), 0);
    chk("R7", "fourth luma after reset with skew 3", int'(ol[3]), 40);

    // R4: latency of a lone sample
    do_reset();
    begin
      int sent_at;
      send(10'd77, 10'd99, 11'd9, 3'd5, 1'b0, 1'b0, 11'd0, 11'd0);
      sent_at = cyc;
      idle(10);
      chk("R4", "latency cycles", first_out - sent_at, 4);
      chk("R4", "single output pulse", ocnt, 1);
    end

    // R6: mid-line code changes are held until the next line number
    do_reset();
    for (int s = 0; s < 5; s++)
      send(10'(100 + s), 10'(200 + s), 11'd5, (s < 2) ? 3'd2 : 3'd0, 1'b0, 1'b0, 11'd0, 11'd0);
    idle(1);
    for (int s = 0; s < 5; s++)
      send(10'(110 + s), 10'(210 + s), 11'd6, (s == 0) ? 3'd6 : 3'd1, 1'b0, 1'b0, 11'd0, 11'd0);
    for (int s = 0; s < 4; s++)
      send(10'(120 + s), 10'(220 + s), 11'd7, 3'd1, 1'b1, 1'b1, 11'd7, 11'd8);
    verify("R6");
    chk("R6", "luma held back on line 5 tail", int'(ol[4]), 102);
    chk("R6", "chroma held back on line 6 tail", int'(oc[9]), 212);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule